// File: doc/BRIEF.md
# Two-Master Internal Bus Arbiter

This block decides which of two masters owns an on-chip bus: the processor core or the DMA engine, which speaks for all of its channels with one request line. A transfer, once granted, runs until the bus signals that it is complete. Each time the bus is free, or a transfer completes, the arbiter looks at the two requests and picks a winner. Which master wins a contested cycle depends on a 2-bit scheme field: alternate between masters, always favour the core, always favour the DMA, or favour whoever held the bus last.

The scheme is held in an 8-bit control register that software writes through a simple write strobe and reads back at all times. The DMA can also assert a maximum-bandwidth flag, which lets it win a contested cycle under every scheme. When neither master requests, no grant is driven, but the last owner is remembered so that the parking schemes know whom to favour.

Top module: `bus_arb2`

## Requirements
- R1: The control register is 8 bits and resets to 0x00. A write (reg_wr high at a clock edge) stores reg_wdata, except that bits 2 and 1 always read 0. The scheme is bits 7:6, an internal-arbitration flag is bit 5, the external-arbitration flag is bit 4, a show-data flag is bit 3, and a counter-mode flag is bit 0. reg_rdata always shows the stored value.
- R2: At most one of gnt_core and gnt_dma is high. While a grant is high, owner names that master (0 = core, 1 = DMA). After reset no grant is high and owner is 0.
- R3: A granted transfer is never preempted. Grants and owner hold until a cycle in which xfer_done is high.
- R4: An arbitration point is a cycle with no grant or with xfer_done high. The winner chosen there is granted from the next cycle. If neither master requests at that point, no grant follows and owner keeps its value.
- R5: At an arbitration point where only one master requests, that master wins under every scheme.
- R6: Scheme 00 (alternate): when both request, the master other than owner wins. The exception is the first grant after reset, which goes to the core.
- R7: Scheme 01 (core parked): when both request, the core wins.
- R8: Scheme 10 (DMA parked): when both request, the DMA wins.
- R9: Scheme 11 (last owner parked): when both request, the master named by owner wins again.
- R10: When both request and dma_maxbw is high, the DMA wins whatever the scheme and the external-arbitration flag.
- R11: While the external-arbitration flag (bit 4) is 1, the scheme field is ignored and the core wins a contested cycle, except as R10 says.
- R12: A register write takes effect for arbitration from the cycle after the write edge. The arbitration decision made at that same edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| req_core | input | 1 | Core bus request |
| req_dma | input | 1 | DMA bus request (all channels combined) |
| dma_maxbw | input | 1 | DMA is running at maximum bandwidth |
| xfer_done | input | 1 | The current transfer completes this cycle |
| gnt_core | output | 1 | Bus granted to the core |
| gnt_dma | output | 1 | Bus granted to the DMA |
| owner | output | 1 | Current or last bus owner, 0 = core, 1 = DMA |

## Verification
The bound checker checks several rules on every cycle: that the grants never overlap and agree with owner, that a transfer is never preempted, that an idle arbitration point leaves the bus ungranted, and the winner of each contested cycle under the maximum-bandwidth flag and under each scheme. Some behaviour can only be shown by the bench's scenarios. These include the first grant after reset under the alternate scheme and the register's masked read-back. They also include the effect of a register write that lands on the same edge as an arbitration decision. The bench shows these by comparing every cycle against its own model across long random runs in all four schemes.

// File: rtl/bus_arb2_pkg.sv
`timescale 1ns/1ps
// Package: shared types and field positions for the two-master bus arbiter.
// Assumes an 8-bit control register; field positions are fixed by decoding.
package bus_arb2_pkg;

    localparam int CTL_W     = 8;
    localparam int MODE_HI   = 7;
    localparam int MODE_LO   = 6;
    localparam int IARB_BIT  = 5;
    localparam int EARB_BIT  = 4;
    localparam int SHOW_BIT  = 3;
    localparam int CNT24_BIT = 0;

    // Writable bits of the control register; the rest read as zero.
    localparam logic [CTL_W-1:0] CTL_WMASK =
        (CTL_W'(1) << MODE_HI) | (CTL_W'(1) << MODE_LO) |
        (CTL_W'(1) << IARB_BIT) | (CTL_W'(1) << EARB_BIT) |
        (CTL_W'(1) << SHOW_BIT) | (CTL_W'(1) << CNT24_BIT);

    typedef enum logic [1:0] {
        SCH_ALTERNATE = 2'b00,
        SCH_PARK_CORE = 2'b01,
        SCH_PARK_DMA  = 2'b10,
        SCH_PARK_LAST = 2'b11
    } arb_scheme_e;

    typedef struct packed {
        arb_scheme_e scheme;
        logic        ext_arb;
    } arb_cfg_t;

endpackage

// File: rtl/bus_arb2_ctlreg.sv
`timescale 1ns/1ps
// Module: control register. It holds the scheme and the flag bits, masks the
// reserved bits on write and decodes the fields the arbiter needs.
// Assumes a single write strobe with no address decode at this level.
module bus_arb2_ctlreg
    import bus_arb2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output arb_cfg_t         cfg
);

    logic [CTL_W-1:0] ctl_q;

    // Store the masked write data; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wdata & CTL_WMASK;
        end
    end

    // Decode the fields that steer arbitration.
    always_comb begin
        rdata       = ctl_q;
        cfg.scheme  = arb_scheme_e'(ctl_q[MODE_HI:MODE_LO]);
        cfg.ext_arb = ctl_q[EARB_BIT];
    end

endmodule

// File: rtl/bus_arb2_policy.sv
`timescale 1ns/1ps
// Module: winner selection. Purely combinational. It resolves a contested cycle
// using the maximum-bandwidth flag, the external-arbitration fallback and
// the selected scheme. A lone requester always wins.
// Assumes last_dma and fresh come from registered state in the tracker.
module bus_arb2_policy
    import bus_arb2_pkg::*;
(
    input  arb_cfg_t cfg,
    input  logic     req_core,
    input  logic     req_dma,
    input  logic     dma_maxbw,
    input  logic     last_dma,
    input  logic     fresh,
    output logic     any_req,
    output logic     win_dma
);

    logic favour_dma;

    // Decide which master a contested cycle favours.
    always_comb begin
        if (dma_maxbw) begin
            favour_dma = 1'b1;
        end else if (cfg.ext_arb) begin
            favour_dma = 1'b0;
        end else begin
            unique case (cfg.scheme)
                SCH_ALTERNATE: favour_dma = fresh ? 1'b0 : ~last_dma;
                SCH_PARK_CORE: favour_dma = 1'b0;
                SCH_PARK_DMA:  favour_dma = 1'b1;
                SCH_PARK_LAST: favour_dma = last_dma;
                default:       favour_dma = 1'b0;
            endcase
        end
    end

    // Combine the preference with the actual requests.
    always_comb begin
        any_req = req_core | req_dma;
        if (req_core && req_dma) begin
            win_dma = favour_dma;
        end else begin
            win_dma = req_dma;
        end
    end

endmodule

// File: rtl/bus_arb2_track.sv
`timescale 1ns/1ps
// Module: ownership tracker. It holds the busy flag, the current or last
// owner, and a flag marking that no grant has occurred since reset.
// Assumes xfer_done is only meaningful while busy.
module bus_arb2_track (
    input  logic clk,
    input  logic rst_n,
    input  logic any_req,
    input  logic win_dma,
    input  logic xfer_done,
    output logic busy,
    output logic owner_dma,
    output logic fresh
);

    logic arb_point;

    // Arbitration happens when the bus is free or a transfer ends.
    always_comb arb_point = ~busy | xfer_done;

    // Update ownership at each arbitration point; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            owner_dma <= 1'b0;
            fresh     <= 1'b1;
        end else if (arb_point) begin
            if (any_req) begin
                busy      <= 1'b1;
                owner_dma <= win_dma;
                fresh     <= 1'b0;
            end else begin
                busy      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_arb2.sv
`timescale 1ns/1ps
// Module: top of the two-master bus arbiter. It ties together the control
// register, the winner selection and the ownership tracker, and derives
// the one-hot grants from the tracked state.
// Assumes the masters hold their requests until granted.
module bus_arb2
    import bus_arb2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             req_core,
    input  logic             req_dma,
    input  logic             dma_maxbw,
    input  logic             xfer_done,
    output logic             gnt_core,
    output logic             gnt_dma,
    output logic             owner
);

    arb_cfg_t cfg;
    logic     any_req;
    logic     win_dma;
    logic     busy;
    logic     owner_dma;
    logic     fresh;

    bus_arb2_ctlreg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    bus_arb2_policy u_pol (
        .cfg       (cfg),
        .req_core  (req_core),
        .req_dma   (req_dma),
        .dma_maxbw (dma_maxbw),
        .last_dma  (owner_dma),
        .fresh     (fresh),
        .any_req   (any_req),
        .win_dma   (win_dma)
    );

    bus_arb2_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .win_dma   (win_dma),
        .xfer_done (xfer_done),
        .busy      (busy),
        .owner_dma (owner_dma),
        .fresh     (fresh)
    );

    // Drive the grants from the registered ownership state.
    always_comb begin
        gnt_core = busy & ~owner_dma;
        gnt_dma  = busy &  owner_dma;
        owner    = owner_dma;
    end

endmodule

// File: rtl/bus_arb2_chk.sv
`timescale 1ns/1ps
// Module: property checker for the arbiter. It is bound to every instance of
// bus_arb2 and observes ports only.
module bus_arb2_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       req_core,
    input logic       req_dma,
    input logic       dma_maxbw,
    input logic       xfer_done,
    input logic       gnt_core,
    input logic       gnt_dma,
    input logic       owner
);

    logic arb_pt;
    logic both;
    logic plain;

    // Classify the current cycle from the port values.
    always_comb begin
        arb_pt = ~(gnt_core | gnt_dma) | xfer_done;
        both   = req_core & req_dma;
        plain  = arb_pt & both & ~dma_maxbw & ~reg_rdata[4];
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_core, gnt_dma})); // R2

    AST_OWNER_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_core |-> !owner) and (gnt_dma |-> owner)); // R2

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_core | gnt_dma) && !xfer_done) |=>
            ($stable({gnt_core, gnt_dma}) && $stable(owner))); // R3

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && !req_core && !req_dma) |=>
            (!gnt_core && !gnt_dma && $stable(owner))); // R4

    AST_SOLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && req_core && !req_dma) |=> gnt_core); // R5

    AST_MAXBW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && both && dma_maxbw) |=> gnt_dma); // R10

    AST_EXT_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && both && !dma_maxbw && reg_rdata[4]) |=> gnt_core); // R11

    AST_ALT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && reg_rdata[7:6] == 2'b00 && (gnt_core | gnt_dma)) |=>
            (owner != $past(owner))); // R6

    AST_PARK_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && reg_rdata[7:6] == 2'b01) |=> gnt_core); // R7

    AST_PARK_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && reg_rdata[7:6] == 2'b10) |=> gnt_dma); // R8

    AST_PARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && reg_rdata[7:6] == 2'b11) |=> (owner == $past(owner))); // R9

endmodule

bind bus_arb2 bus_arb2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .req_core  (req_core),
    .req_dma   (req_dma),
    .dma_maxbw (dma_maxbw),
    .xfer_done (xfer_done),
    .gnt_core  (gnt_core),
    .gnt_dma   (gnt_dma),
    .owner     (owner)
);

// File: tb/bus_arb2_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic in every scheme.
// Each cycle is compared against a reference model kept in the bench.
module bus_arb2_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       req_core = 1'b0;
    logic       req_dma = 1'b0;
    logic       dma_maxbw = 1'b0;
    logic       xfer_done = 1'b0;
    logic       gnt_core;
    logic       gnt_dma;
    logic       owner;

    int total = 0;
    int bad = 0;

    // Reference state
    logic       m_busy, m_owner, m_first;
    logic [7:0] m_reg;

    always #4 clk = ~clk;

    bus_arb2 uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_core(req_core), .req_dma(req_dma),
        .dma_maxbw(dma_maxbw), .xfer_done(xfer_done), .gnt_core(gnt_core),
        .gnt_dma(gnt_dma), .owner(owner)
    );

    // Expected winner of an arbitration point: 1 means DMA.
    function automatic logic ref_win(input logic rc, input logic rd,
                                     input logic mb, input logic [7:0] r,
                                     input logic own, input logic first);
        if (!(rc && rd)) return rd;
        if (mb) return 1'b1;                     // R10
        if (r[4]) return 1'b0;                   // R11
        case (r[7:6])
            2'b00:   return first ? 1'b0 : !own; // R6
            2'b01:   return 1'b0;                // R7
            2'b10:   return 1'b1;                // R8
            default: return own;                 // R9
        endcase
    endfunction

    function automatic string auto_tag(input logic rc, input logic rd,
                                       input logic mb, input logic [7:0] r,
                                       input logic arb);
        if (!arb) return "R3";
        if (!(rc || rd)) return "R4";
        if (!(rc && rd)) return "R5";
        if (mb) return "R10";
        if (r[4]) return "R11";
        case (r[7:6])
            2'b00:   return "R6";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [2:0] act, exp;
        act = {gnt_core, gnt_dma, owner};
        exp = {m_busy & !m_owner, m_busy & m_owner, m_owner};
        total++;
        if (act !== exp || reg_rdata !== m_reg) begin
            bad++;
            $display("FAIL %s: gc/gd/own=%b rdata=%h expected %b rdata=%h",
                     tag, act, reg_rdata, exp, m_reg);
        end
    endtask

    // Drive one cycle, advance the model, check at the next falling edge.
    task automatic step(input logic rc, input logic rd, input logic dn,
                        input logic mb, input logic wr, input logic [7:0] wd,
                        input string tag);
        logic arb;
        string t;
        req_core = rc; req_dma = rd; xfer_done = dn; dma_maxbw = mb;
        reg_wr = wr; reg_wdata = wd;
        arb = !m_busy || dn;
        t = (tag == "") ? auto_tag(rc, rd, mb, m_reg, arb) : tag;
        if (arb) begin
            if (rc || rd) begin
                m_owner = ref_win(rc, rd, mb, m_reg, m_owner, m_first);
                m_busy  = 1'b1;
                m_first = 1'b0;
            end else begin
                m_busy = 1'b0;
            end
        end
        if (wr) m_reg = wd & 8'hF9; // R12: applied after this edge's decision
        @(negedge clk);
        compare(t);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_busy = 0; m_owner = 0; m_first = 1; m_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 R2 reset");
        // R6: first contest after reset goes to the core, then alternates
        step(1, 1, 0, 0, 0, 8'h00, "R6 first");
        step(1, 1, 1, 0, 0, 8'h00, "R6 swap");
        step(1, 1, 0, 0, 0, 8'h00, "R3 hold");
        step(0, 0, 1, 0, 0, 8'h00, "R4 release");
        step(0, 0, 0, 0, 0, 8'h00, "R4 parked owner");
        // R1: reserved bits masked
        step(0, 0, 0, 0, 1, 8'hFF, "R1 mask");
        // R11: ext flag forces core even in scheme 11
        step(1, 1, 0, 0, 0, 8'h00, "R11 ext");
        // R12: write to scheme 10 on same edge as a decision uses old value
        step(1, 1, 1, 0, 1, 8'h80, "R12 old value");
        step(1, 1, 1, 0, 0, 8'h00, "R8 park dma");
        step(1, 1, 1, 0, 1, 8'h40, "R8 before write");
        step(1, 1, 1, 0, 0, 8'h00, "R7 park core");
        step(1, 1, 1, 1, 0, 8'h00, "R10 maxbw");
        step(1, 0, 1, 0, 1, 8'hC0, "R5 sole core");
        step(1, 1, 1, 0, 0, 8'h00, "R9 keep core");
        step(0, 1, 1, 0, 0, 8'h00, "R5 sole dma");
        step(1, 1, 1, 0, 0, 8'h00, "R9 keep dma");
        step(0, 0, 1, 0, 0, 8'h00, "R4 idle");
        step(1, 1, 0, 0, 0, 8'h00, "R9 idle keep");
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 20000; i++) begin
            logic wr;
            logic [7:0] wd;
            wr = ($urandom_range(0, 39) == 0);
            wd = 8'($urandom());
            if (wr && $urandom_range(0, 3) != 0) wd[4] = 1'b0;
            step($urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0,
                 wr, wd, "");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule